// File: doc/BRIEF.md
# Two-Step Coarse/Fine ADC Sequencer

This block is the digital half of a 14-bit column converter that resolves each sample in two passes over a single comparator. A start pulse launches a 7-bit successive-approximation pass. Each cycle the block presents a trial code to the capacitor DAC, reads the comparator and settles one bit, working from the most significant bit down. The block then holds the settled coarse code on the DAC and enables an external ramp for a 7-bit single-slope pass. A counter runs in step with the ramp, and its value is latched in the cycle the comparator trips.

The coarse code and the fine count are packed into one 14-bit word. A one-cycle done strobe marks the word as valid. Start requests that arrive while a conversion is in flight are dropped. The capacitor array, ramp and comparator are outside this block.

Top module: `twostep_adc_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, busy_o, done_o, ramp_run_o, dac_code_o and result_o are all zero.
- R2: In the first coarse cycle after an accepted start, dac_code_o equals 7'b1000000. Each coarse cycle keeps the trial bit when cmp_i is 1 (input at or above the DAC level) and clears it otherwise, then trials the next lower bit. The settled code appears in result_o[13:7].
- R3: The coarse pass lasts exactly 7 cycles with ramp_run_o low. ramp_run_o is then high for the whole fine pass, and dac_code_o holds the settled coarse code during that pass.
- R4: The fine count starts at 0 in the first ramp cycle and rises by one per cycle. The value in the cycle where cmp_i is first 1 is stored in result_o[6:0].
- R5: If cmp_i stays 0 through fine count 127, the fine field saturates at 127 and the fine pass ends after 128 cycles.
- R6: done_o is high for exactly one cycle per conversion, result_o is valid in that cycle, and result_o holds its value until the next done pulse.
- R7: A start_i pulse during a conversion, including the cycle where done_o is high, has no effect on the result or the timing.
- R8: Counting the start edge as edge 1, done_o rises after edge 9+F, where F is the stored fine field.
- R9: busy_o is high from the cycle after an accepted start through the done cycle, then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a conversion, sampled only when idle |
| cmp_i | input | 1 | Comparator decision shared by both passes |
| dac_code_o | output | 7 | Trial or settled coarse code driving the capacitor DAC |
| ramp_run_o | output | 1 | Enables the external ramp during the fine pass |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle strobe marking result_o valid |
| result_o | output | 14 | Coarse code in [13:7], fine count in [6:0] |

## Verification
A wrong bit decision in the successive-approximation register appears on dac_code_o in the next cycle. It also changes the residue the bench's ramp model must cover, so result_o and the done latency both move. A counter that starts at the wrong value or misses saturation shows up in the fine field and in the done timing of that same conversion. Because of this, every conversion compares the whole word against the bench's applied input and checks the exact edge at which done arrives. The 7th-cycle handover and the first trial code are each sampled at their own cycle.

// File: rtl/twostep_pkg.sv
package twostep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COARSE = 2'd1,
    ST_FINE   = 2'd2,
    ST_DONE   = 2'd3
  } ts_state_e;
endpackage

// File: rtl/ts_sequencer.sv
module ts_sequencer
  import twostep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      coarse_last_i,
  input  logic      fine_stop_i,
  output ts_state_e state_o,
  output logic      accept_o
);
  ts_state_e state_q, state_d;

  assign accept_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_o)      state_d = ST_COARSE;
      ST_COARSE: if (coarse_last_i) state_d = ST_FINE;
      ST_FINE:   if (fine_stop_i)   state_d = ST_DONE;
      ST_DONE:                      state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ts_sar_reg.sv
module ts_sar_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] trial_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q, code_d;
  logic [W-1:0] mask_q, mask_d;
  logic         en;

  assign en = load_i || step_i;

  always_comb begin
    code_d = code_q;
    mask_d = mask_q;
    if (load_i) begin
      code_d = '0;
      mask_d = TOP_BIT;
    end else if (step_i) begin
      code_d = code_q | (cmp_i ? mask_q : '0);
      mask_d = mask_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (en) begin
      code_q <= code_d;
      mask_q <= mask_d;
    end
  end

  assign code_o  = code_q;
  assign trial_o = code_q | mask_q;
  assign last_o  = mask_q[0];
endmodule

// File: rtl/ts_fine_counter.sv
module ts_fine_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic         cmp_i,
  output logic [W-1:0] count_o,
  output logic         stop_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_max, en;

  assign at_max = &cnt_q;
  assign stop_o = run_i && (cmp_i || at_max);
  assign en     = clear_i || (run_i && !at_max);

  always_comb begin
    if (clear_i) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/twostep_adc_ctrl.sv
module twostep_adc_ctrl
  import twostep_pkg::*;
#(
  parameter int COARSE_W = 7,
  parameter int FINE_W   = 7,
  localparam int RES_W   = COARSE_W + FINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                cmp_i,
  output logic [COARSE_W-1:0] dac_code_o,
  output logic                ramp_run_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [RES_W-1:0]    result_o
);
  ts_state_e           state;
  logic                accept, coarse_last, fine_stop;
  logic [COARSE_W-1:0] coarse_code, coarse_trial;
  logic [FINE_W-1:0]   fine_count;
  logic                in_coarse, in_fine, capture;
  logic [RES_W-1:0]    result_q, result_d;
  logic                done_q;

  assign in_coarse = (state == ST_COARSE);
  assign in_fine   = (state == ST_FINE);
  assign capture   = in_fine && fine_stop;

  ts_sequencer u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .coarse_last_i (coarse_last && in_coarse),
    .fine_stop_i   (fine_stop),
    .state_o       (state),
    .accept_o      (accept)
  );

  ts_sar_reg #(.W(COARSE_W)) u_sar (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .step_i  (in_coarse),
    .cmp_i   (cmp_i),
    .code_o  (coarse_code),
    .trial_o (coarse_trial),
    .last_o  (coarse_last)
  );

  ts_fine_counter #(.W(FINE_W)) u_fine (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .run_i   (in_fine),
    .cmp_i   (cmp_i),
    .count_o (fine_count),
    .stop_o  (fine_stop)
  );

  always_comb begin
    result_d = result_q;
    if (capture) result_d = {coarse_code, fine_count};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= capture;
      if (capture) result_q <= result_d;
    end
  end

  always_comb begin
    unique case (state)
      ST_COARSE: dac_code_o = coarse_trial;
      ST_FINE:   dac_code_o = coarse_code;
      default:   dac_code_o = '0;
    endcase
  end

  assign ramp_run_o = in_fine;
  assign busy_o     = (state != ST_IDLE);
  assign done_o     = done_q;
  assign result_o   = result_q;
endmodule

// File: rtl/twostep_adc_checker.sv
module twostep_adc_checker #(
  parameter int COARSE_W = 7,
  parameter int FINE_W   = 7,
  localparam int RES_W   = COARSE_W + FINE_W,
  localparam int RAMP_MAX = 1 << FINE_W,
  localparam int RC_W    = FINE_W + 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [COARSE_W-1:0] dac_code_o,
  input logic                ramp_run_o,
  input logic                busy_o,
  input logic                done_o,
  input logic [RES_W-1:0]    result_o
);
  logic [RC_W-1:0] ramp_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ramp_cnt <= '0;
    else if (ramp_run_o) ramp_cnt <= ramp_cnt + 1'b1;
    else                 ramp_cnt <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (dac_code_o == '0 && !ramp_run_o && !done_o));

  p_coarse_first_trial_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (dac_code_o == {1'b1, {(COARSE_W-1){1'b0}}}));

  p_ramp_under_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_run_o |-> busy_o);

  p_dac_hold_fine_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_run_o && $past(ramp_run_o)) |-> $stable(dac_code_o));

  p_fine_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_run_o |-> (ramp_cnt < RC_W'(RAMP_MAX)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || $stable(result_o)));

  p_fine_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_run_o && start_i) |=> (ramp_run_o || done_o));

  p_busy_until_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
endmodule

bind twostep_adc_ctrl twostep_adc_checker #(
  .COARSE_W (COARSE_W),
  .FINE_W   (FINE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .dac_code_o (dac_code_o),
  .ramp_run_o (ramp_run_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/tb_twostep_adc_ctrl.sv
module tb_twostep_adc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        cmp_i;
  logic [6:0]  dac_code_o;
  logic        ramp_run_o, busy_o, done_o;
  logic [13:0] result_o;

  logic [13:0] vin = '0;
  logic        sat_mode = 1'b0;
  logic [7:0]  k;
  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  twostep_adc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .ramp_run_o(ramp_run_o), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o)
  );

  // ramp position: cycles since ramp enable rose
  always @(posedge clk) begin
    if (!ramp_run_o) k <= 8'd0;
    else             k <= k + 8'd1;
  end

  always_comb begin
    if (ramp_run_o) cmp_i = sat_mode ? 1'b0 : (k >= {1'b0, vin[6:0]});
    else            cmp_i = (vin >= {dac_code_o, 7'd0});
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input logic [13:0] v, input bit sat, input bit poke);
    int edges;
    int fine_exp;
    logic [13:0] exp;
    bit got;
    fine_exp = sat ? 127 : int'(v[6:0]);
    exp = {v[13:7], 7'(fine_exp)};
    @(negedge clk);
    vin = v; sat_mode = sat; start_i = 1'b1;
    edges = 0; got = 0;
    while (!got && edges < 300) begin
      @(posedge clk); edges++;
      @(negedge clk);
      start_i = poke && (edges == 3 || edges == 12);
      if (edges == 1)
        check(dac_code_o == 7'h40 && !ramp_run_o && busy_o, "R2", dac_code_o, 64);
      if (edges == 7)
        check(!ramp_run_o, "R3", ramp_run_o, 0);
      if (edges == 8)
        check(ramp_run_o && dac_code_o == v[13:7], "R3", dac_code_o, v[13:7]);
      if (done_o) got = 1;
    end
    if (!got) check(1'b0, "R8 watchdog", edges, 9 + fine_exp);
    check(edges == 9 + fine_exp, sat ? "R5" : "R8", edges, 9 + fine_exp);
    check(result_o[13:7] == v[13:7], "R2", result_o[13:7], v[13:7]);
    check(result_o[6:0] == 7'(fine_exp), sat ? "R5" : "R4", result_o[6:0], fine_exp);
    check(busy_o, "R9", busy_o, 1);
    start_i = poke;   // request during the done cycle must be dropped
    @(negedge clk);
    start_i = 1'b0;
    check(!done_o && !busy_o, "R7", {done_o, busy_o}, 0);
    check(result_o == exp, "R6", result_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !ramp_run_o && dac_code_o == 0 && result_o == 0, "R1", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && !ramp_run_o && dac_code_o == 0 && result_o == 0, "R1", busy_o, 0);
    // every coarse code, varied fine residue
    for (int c = 0; c < 128; c++)
      convert({7'(c), 7'((c * 37 + 5) % 128)}, 1'b0, c[0]);
    // every fine residue, two coarse codes
    for (int f = 0; f < 128; f++)
      convert({7'((f % 2 == 0) ? 42 : 85), 7'(f)}, 1'b0, f[1]);
    // corners
    convert(14'h0000, 1'b0, 1'b1);
    convert(14'h3fff, 1'b0, 1'b1);
    convert(14'h2000, 1'b0, 1'b0);
    convert(14'h1fff, 1'b0, 1'b0);
    // never-tripping ramp: saturation (R5)
    convert({7'd17, 7'd3}, 1'b1, 1'b1);
    convert({7'd127, 7'd0}, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule